// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps the time of day for a digital clock as three pairs of BCD digits: seconds, minutes and hours. All state sits on one system clock. The chain advances only when a single-cycle one-pulse-per-second enable (`tick`) is high. The oscillator and the prescaler that produce that pulse sit outside the block, and so does the seven-segment decoding of the six output nibbles.

The seconds and minutes stages are built the same way. Each has a ones digit that counts modulo 10, feeding a tens digit that counts modulo 6. A stage passes a one-cycle carry to the next stage when it sits at 59 while its own enable is high. The hours stage runs either 00..23 or 00..11, selected by a static mode input. The ones digit rolls from 9 into the tens digit, and the terminal hour clears both digits.

To set the time, the user raises `set_hours`. The hours stage then advances on every `tick` instead of on the minute-stage carry. Seconds and minutes keep counting during this.

Top module: `bcd_clock_chain`

## Requirements
- R1: A synchronous active-high `rst` sets all six output nibbles to 0 at the next rising clock edge.
- R2: Each edge with `tick` high adds one second. The seconds ones digit counts 0..9 and carries into the seconds tens digit. With `tick` low, the seconds do not change.
- R3: When seconds are 59 and `tick` is high, seconds go to 00 and the minutes advance by one on the same edge.
- R4: Minutes count 00..59 like seconds. With `set_hours` low, minutes wrap from 59 to 00 at the edge where the seconds wrap, and the hours advance by one on that edge.
- R5: Every ones digit stays in 0..9, and every seconds or minutes tens digit stays in 0..5, so bit 3 of those tens nibbles is always 0.
- R6: With `mode24` = 1, an hours increment goes 09→10, 19→20 and 23→00, so hours stay in 00..23.
- R7: With `mode24` = 0, an hours increment goes 09→10 and 11→00, so 12 never appears.
- R8: With `set_hours` = 1, the hours advance by one on every `tick` edge and ignore the minute carry. With `set_hours` = 0, the hours advance only on the minute carry.
- R9: `mode24` takes effect at the next hours increment. If the hours value is then at or above the terminal count of the new mode, that increment clears the hours to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle one-per-second enable |
| mode24 | input | 1 | 1: 24-hour range, 0: 12-hour range (00..11) |
| set_hours | input | 1 | 1: hours advance on every tick |
| sec_ones | output | 4 | Seconds ones digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes ones digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours ones digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |

## Verification
Every digit register drives an output directly, so a wrong internal state shows at the ports at the same edge it is written. The bench compares all six nibbles after every clock and catches it within one cycle.

A missing or doubled carry is the slower case. It shows up only at the next rollover: after up to 10 ticks for a ones-to-tens carry, and after up to 3600 ticks for the hour carry. For this reason the bench runs through a complete natural hour rollover and also through the fast path that uses `set_hours`.

// File: rtl/bcd_clock_chain.sv
module bcd_clock_chain (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       mode24,
  input  logic       set_hours,
  output logic [3:0] sec_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [3:0] min_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] hr_tens
);

  logic s1_cy, s_cy, m1_cy, m_cy, h_en, h_wrap;
  logic [7:0] sec_v, min_v, hr_v;

  assign sec_v = {sec_tens, sec_ones};
  assign min_v = {min_tens, min_ones};
  assign hr_v  = {hr_tens, hr_ones};

  assign s1_cy = tick  && (sec_ones == 4'd9);
  assign s_cy  = s1_cy && (sec_tens == 4'd5);
  assign m1_cy = s_cy  && (min_ones == 4'd9);
  assign m_cy  = m1_cy && (min_tens == 4'd5);
  assign h_en  = set_hours ? tick : m_cy;
  assign h_wrap = mode24 ? (hr_v >= 8'h23) : (hr_v >= 8'h11);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_ones <= '0;
      sec_tens <= '0;
    end else begin
      if (tick)  sec_ones <= s1_cy ? 4'd0 : sec_ones + 4'd1;
      if (s1_cy) sec_tens <= s_cy  ? 4'd0 : sec_tens + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min_ones <= '0;
      min_tens <= '0;
    end else begin
      if (s_cy)  min_ones <= m1_cy ? 4'd0 : min_ones + 4'd1;
      if (m1_cy) min_tens <= m_cy  ? 4'd0 : min_tens + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_ones <= '0;
      hr_tens <= '0;
    end else if (h_en) begin
      if (h_wrap) begin
        hr_ones <= '0;
        hr_tens <= '0;
      end else if (hr_ones == 4'd9) begin
        hr_ones <= '0;
        hr_tens <= hr_tens + 4'd1;
      end else begin
        hr_ones <= hr_ones + 4'd1;
      end
    end
  end

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sec_v));

  a_r3_seconds_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && sec_v == 8'h59) |=> (sec_v == 8'h00) && !$stable(min_v));

  a_r4_hour_carry: assert property (@(posedge clk) disable iff (rst)
    (!set_hours && tick && sec_v == 8'h59 && min_v == 8'h59)
      |=> (min_v == 8'h00) && !$stable(hr_v));

  a_r5_digit_range: assert property (@(posedge clk) disable iff (rst)
    sec_ones <= 4'd9 && min_ones <= 4'd9 && hr_ones <= 4'd9 &&
    sec_tens <= 4'd5 && min_tens <= 4'd5);

  a_r6_range_24: assert property (@(posedge clk) disable iff (rst)
    (h_en && mode24) |=> hr_v <= 8'h23);

  a_r7_range_12: assert property (@(posedge clk) disable iff (rst)
    (h_en && !mode24) |=> hr_v <= 8'h11);

  a_r8_set_advances: assert property (@(posedge clk) disable iff (rst)
    (set_hours && tick) |=> !$stable(hr_v));

endmodule

// File: tb/tb_bcd_clock_chain.sv
module tb_bcd_clock_chain;
  logic clk = 0, rst = 1, tick = 0, mode24 = 0, set_hours = 0;
  logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;

  int compared = 0, mismatched = 0;
  int ms = 0, mm = 0, mh = 0;
  bit finished = 0;

  bcd_clock_chain dut (.clk(clk), .rst(rst), .tick(tick), .mode24(mode24),
    .set_hours(set_hours), .sec_ones(sec_ones), .sec_tens(sec_tens),
    .min_ones(min_ones), .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens));

  always #2 clk = ~clk;

  function automatic int bcd2i(input logic [3:0] t, input logic [3:0] o);
    return int'(t) * 10 + int'(o);
  endfunction

  task automatic model_step();
    int lim;
    bit hen;
    if (rst) begin ms = 0; mm = 0; mh = 0; return; end
    hen = set_hours ? tick : (tick && ms == 59 && mm == 59);
    if (tick) begin
      if (ms == 59) begin ms = 0; mm = (mm == 59) ? 0 : mm + 1; end
      else ms = ms + 1;
    end
    lim = mode24 ? 23 : 11;
    if (hen) mh = (mh >= lim) ? 0 : mh + 1;
  endtask

  task automatic compare(input string tag);
    compared++;
    if (bcd2i(sec_tens, sec_ones) != ms || bcd2i(min_tens, min_ones) != mm ||
        bcd2i(hr_tens, hr_ones) != mh || sec_tens > 5 || min_tens > 5 ||
        sec_ones > 9 || min_ones > 9 || hr_ones > 9) begin
      mismatched++;
      $display("FAIL %s: got %h%h:%h%h:%h%h expected %02d:%02d:%02d", tag,
        hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones, mh, mm, ms);
    end
  endtask

  task automatic cycle(input bit t, input string tag);
    tick = t;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic burst(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1'b1, tag);
  endtask

  task automatic sparse(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1'($urandom_range(0, 1)), tag);
  endtask

  initial begin
    @(negedge clk);
    rst = 1;
    cycle(1'b0, "R1 reset");
    cycle(1'b0, "R1 reset");
    rst = 0;
    cycle(1'b0, "R1 hold after reset");
    sparse(300, "R2 seconds count");
    burst(25, "R2 seconds burst");
    for (int i = 0; i < 8; i++) cycle(1'b0, "R2 no tick hold");
    burst(100, "R3 seconds wrap");
    sparse(500, "R5 digit range");
    rst = 1; cycle(1'b0, "R1 mid-run reset"); rst = 0;
    mode24 = 0; set_hours = 1;
    burst(15, "R8 set bypass");
    burst(14, "R7 twelve-hour wrap 11 to 00");
    set_hours = 0;
    burst(3700, "R4 minutes and hour carry");
    mode24 = 1; set_hours = 1;
    for (int i = 0; i < 30; i++) begin
      cycle(1'b1, "R6 24h hours sequence");
      cycle(1'b0, "R8 set idle");
    end
    while (mh != 23) cycle(1'b1, "R6 reach 23");
    set_hours = 0;
    while (!(ms == 59 && mm == 59)) cycle(1'b1, "R4 run to hour end");
    cycle(1'b1, "R6 natural 23 to 00 via carry");
    set_hours = 1;
    while (mh != 20) cycle(1'b1, "R8 set to 20");
    mode24 = 0;
    cycle(1'b0, "R9 mode change no effect yet");
    cycle(1'b1, "R9 out-of-range wraps to 00");
    burst(40, "R7 12h after mode change");
    set_hours = 0;
    sparse(400, "R8 carry only when set low");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule